// File: doc/BRIEF.md
# Serial Pattern-Unlock Access Controller

This block sits on an SRAM-style parallel bus with active-low chip, output and write enables. It guards a hidden 64-bit register image. Normally every bus cycle passes through to the memory behind it. The block watches data bit 0 of the write cycles for a 64-bit unlock key. A write whose bit does not match freezes the search, and any read starts it over from the first key bit.

Once the full key has matched, the block claims the next 64 counted bus cycles and holds the memory chip enable inactive for them. It loads its shift image from a parallel capture port. Read cycles then return that image one bit at a time on a dedicated data-bit output. Write cycles replace the image one bit at a time. When all 64 transfer cycles are writes, the new image is presented as a one-clock parallel update. An external active-low abort input can cancel the sequence, unless a lock input masks it.

Top module: `unlock_gate`

## Requirements
- R1: After reset the block is in recognition mode with the key pointer at bit 0. `upd_valid_o` and `rd_oe_o` are low, and `mem_ce_no` follows `bus_ce_ni`.
- R2: A read cycle seen in recognition mode returns the key pointer to bit 0 and clears any mismatch, so the next write is compared with key bit 0.
- R3: A write cycle in recognition mode compares `bus_d0_i` with the key bit at the pointer. On a match the pointer steps by one. A match on the last bit enters transfer mode.
- R4: A mismatching write freezes the pointer. All later writes are ignored until a read cycle or an abort, so a full correct key sent after a mismatch without a read does not unlock.
- R5: The key, in the order it is presented, is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, each sent least significant bit first.
- R6: Outside transfer mode, `mem_ce_no` equals `bus_ce_ni`. This includes the cycles that carry key bits.
- R7: In transfer mode `mem_ce_no` is held high. Transfer mode lasts exactly 64 counted cycles and then returns to recognition mode with the pointer at bit 0.
- R8: At unlock, `cap_img_i` is captured. In the transfer cycle with index k (0..63), a read drives `rd_oe_o` high while chip enable and output enable are low and write enable is high, and `rd_d0_o` shows image bit k.
- R9: In the transfer cycle with index k, a write stores `bus_d0_i` into image bit k. Bit 8*r+b is bit b of register r, so the transfer runs from bit 0 of register 0 to bit 7 of register 7.
- R10: If all 64 transfer cycles were writes, `upd_valid_o` pulses for one clock after the last one, with `upd_img_o` holding the written image. A transfer that contains any read gives no pulse.
- R11: With `abort_lock_i` low, `abort_ni` low for a clock ends transfer mode without an update and resets the pointer to bit 0. With `abort_lock_i` high, `abort_ni` has no effect.
- R12: A cycle counts once, on the first clock at which `bus_ce_ni` is sampled high after being low. It is a write if write enable was low on the last clock with chip enable low. Otherwise it is a read if output enable was low on that clock. Otherwise it is not counted. State changes on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_ce_ni | input | 1 | Bus chip enable, active low |
| bus_oe_ni | input | 1 | Bus output enable, active low |
| bus_we_ni | input | 1 | Bus write enable, active low |
| bus_d0_i | input | 1 | Bus data bit 0 (write value) |
| abort_ni | input | 1 | External abort, active low |
| abort_lock_i | input | 1 | When high, the abort input is ignored |
| cap_img_i | input | 64 | Parallel image captured at unlock |
| mem_ce_no | output | 1 | Chip enable passed on to the memory, active low |
| rd_oe_o | output | 1 | Drive enable for data bit 0 during a transfer read |
| rd_d0_o | output | 1 | Transfer read data bit |
| upd_valid_o | output | 1 | One-clock pulse: a full write transfer has completed |
| upd_img_o | output | 64 | Written image, valid with `upd_valid_o` |

## Verification
The properties assume that the bus enables and data bit are synchronous to `clk_i`. They also assume that write enable, output enable and data are steady on the last clock that chip enable is low, because that clock decides the cycle type and bit. The stimulus changes every bus input only at falling clock edges. It holds chip enable low for one or more whole clocks and keeps the other inputs steady for the whole cycle. The abort input is pulsed for one whole clock, away from the clock at which a cycle ends.

// File: rtl/ug_pkg.sv
package ug_pkg;
  typedef enum logic {
    MODE_MATCH = 1'b0,
    MODE_XFER  = 1'b1
  } ug_mode_e;

  // Presented bit 0 first: C5 3A A3 5C C5 3A A3 5C, each LSB first.
  localparam logic [63:0] UNLOCK_KEY = {8'h5C, 8'hA3, 8'h3A, 8'hC5,
                                        8'h5C, 8'hA3, 8'h3A, 8'hC5};
endpackage

// File: rtl/ug_cyc_detect.sv
module ug_cyc_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic d0_i,
  output logic wr_evt_o,
  output logic rd_evt_o,
  output logic d0_o
);
  logic act_q, wr_q, rd_q, d0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      d0_q  <= 1'b0;
    end else begin
      act_q <= ~ce_ni;
      if (!ce_ni) begin
        wr_q <= ~we_ni;
        rd_q <= ~oe_ni;
        d0_q <= d0_i;
      end
    end
  end

  logic end_w;
  assign end_w    = act_q & ce_ni;
  assign wr_evt_o = end_w & wr_q;
  assign rd_evt_o = end_w & ~wr_q & rd_q;
  assign d0_o     = d0_q;
endmodule

// File: rtl/ug_key_match.sv
module ug_key_match #(
  parameter int              KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY  = '0,
  localparam int             PTR_W = $clog2(KEY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             wr_evt_i,
  input  logic             rd_evt_i,
  input  logic             d0_i,
  output logic             hit_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             miss_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             miss_q;
  logic             last_w, ok_w;

  assign last_w = (ptr_q == PTR_W'(KEY_W - 1));
  assign ok_w   = (d0_i == KEY[ptr_q]);
  assign hit_o  = en_i & ~clr_i & wr_evt_i & ~miss_q & ok_w & last_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      miss_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      miss_q <= 1'b0;
    end else if (en_i) begin
      if (rd_evt_i) begin
        ptr_q  <= '0;
        miss_q <= 1'b0;
      end else if (wr_evt_i && !miss_q) begin
        if (ok_w) ptr_q <= last_w ? '0 : ptr_q + 1'b1;
        else      miss_q <= 1'b1;
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign miss_o = miss_q;
endmodule

// File: rtl/ug_img_shift.sv
module ug_img_shift #(
  parameter int  IMG_W = 64,
  localparam int CNT_W = $clog2(IMG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [IMG_W-1:0] cap_i,
  input  logic             wr_evt_i,
  input  logic             rd_evt_i,
  input  logic             d0_i,
  output logic             done_o,
  output logic             bit_o,
  output logic             upd_o,
  output logic [IMG_W-1:0] img_o
);
  logic [IMG_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             allwr_q, upd_q;
  logic             step_w, last_w, nbit_w;

  assign step_w = act_i & ~clr_i & (wr_evt_i | rd_evt_i);
  assign last_w = (cnt_q == CNT_W'(IMG_W - 1));
  assign nbit_w = wr_evt_i ? d0_i : sh_q[0];
  assign done_o = step_w & last_w;

  // Rotating image: reads see bit k at sh_q[0]; writes land in bit k after a full turn.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      allwr_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (load_i) begin
        sh_q    <= cap_i;
        cnt_q   <= '0;
        allwr_q <= 1'b1;
      end else if (step_w) begin
        sh_q    <= {nbit_w, sh_q[IMG_W-1:1]};
        allwr_q <= allwr_q & wr_evt_i;
        cnt_q   <= last_w ? '0 : cnt_q + 1'b1;
        if (last_w && allwr_q && wr_evt_i) upd_q <= 1'b1;
      end
    end
  end

  assign bit_o = sh_q[0];
  assign upd_o = upd_q;
  assign img_o = sh_q;
endmodule

// File: rtl/unlock_gate.sv
module unlock_gate #(
  parameter int               KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY   = ug_pkg::UNLOCK_KEY,
  parameter int               IMG_W = 64,
  localparam int              PTR_W = $clog2(KEY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_ce_ni,
  input  logic             bus_oe_ni,
  input  logic             bus_we_ni,
  input  logic             bus_d0_i,
  input  logic             abort_ni,
  input  logic             abort_lock_i,
  input  logic [IMG_W-1:0] cap_img_i,
  output logic             mem_ce_no,
  output logic             rd_oe_o,
  output logic             rd_d0_o,
  output logic             upd_valid_o,
  output logic [IMG_W-1:0] upd_img_o
);
  import ug_pkg::*;

  ug_mode_e         mode_q;
  logic             xfer_w, abort_w;
  logic             wr_evt_w, rd_evt_w, d0_w;
  logic             hit_w, miss_w, done_w;
  logic [PTR_W-1:0] ptr_w;

  assign xfer_w  = (mode_q == MODE_XFER);
  assign abort_w = ~abort_ni & ~abort_lock_i;

  ug_cyc_detect i_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_ni   (bus_ce_ni),
    .oe_ni   (bus_oe_ni),
    .we_ni   (bus_we_ni),
    .d0_i    (bus_d0_i),
    .wr_evt_o(wr_evt_w),
    .rd_evt_o(rd_evt_w),
    .d0_o    (d0_w)
  );

  ug_key_match #(.KEY_W(KEY_W), .KEY(KEY)) i_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (~xfer_w),
    .clr_i   (abort_w),
    .wr_evt_i(wr_evt_w),
    .rd_evt_i(rd_evt_w),
    .d0_i    (d0_w),
    .hit_o   (hit_w),
    .ptr_o   (ptr_w),
    .miss_o  (miss_w)
  );

  ug_img_shift #(.IMG_W(IMG_W)) i_img (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (xfer_w),
    .load_i  (hit_w),
    .clr_i   (abort_w),
    .cap_i   (cap_img_i),
    .wr_evt_i(wr_evt_w),
    .rd_evt_i(rd_evt_w),
    .d0_i    (d0_w),
    .done_o  (done_w),
    .bit_o   (rd_d0_o),
    .upd_o   (upd_valid_o),
    .img_o   (upd_img_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= MODE_MATCH;
    else if (abort_w)                 mode_q <= MODE_MATCH;
    else if (!xfer_w && hit_w)        mode_q <= MODE_XFER;
    else if (xfer_w && done_w)        mode_q <= MODE_MATCH;
  end

  assign mem_ce_no = bus_ce_ni | xfer_w;
  assign rd_oe_o   = xfer_w & ~bus_ce_ni & ~bus_oe_ni & bus_we_ni;
endmodule

// File: rtl/ug_chk.sv
module ug_chk #(
  parameter int KEY_W = 64,
  parameter int PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             abort_ni,
  input logic             abort_lock_i,
  input logic             upd_valid_o,
  input logic             xfer_w,
  input logic             wr_evt_w,
  input logic             rd_evt_w,
  input logic             miss_w,
  input logic [PTR_W-1:0] ptr_w
);
  // R3
  key_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_w) |-> ($past(wr_evt_w) && $past(ptr_w) == PTR_W'(KEY_W - 1)));

  // R4
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_w && !rd_evt_w && abort_ni) |=> ($stable(ptr_w) && miss_w));

  // R2
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt_w && !xfer_w) |=> (ptr_w == '0 && !miss_w));

  // R10
  commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (!xfer_w && $past(xfer_w) && $past(wr_evt_w)));

  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abort_ni && !abort_lock_i) |=> (!xfer_w && ptr_w == '0 && !upd_valid_o));
endmodule

bind unlock_gate ug_chk #(.KEY_W(KEY_W), .PTR_W(PTR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .abort_ni    (abort_ni),
  .abort_lock_i(abort_lock_i),
  .upd_valid_o (upd_valid_o),
  .xfer_w      (xfer_w),
  .wr_evt_w    (wr_evt_w),
  .rd_evt_w    (rd_evt_w),
  .miss_w      (miss_w),
  .ptr_w       (ptr_w)
);

// File: tb/test_unlock_gate.sv
module test_unlock_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d0 = 1'b0;
  logic        abort_n = 1'b1, lock = 1'b0;
  logic [63:0] cap = 64'h0123_4567_89AB_CDEF;
  logic        mem_ce_n, rd_oe, rd_d0, upd_v;
  logic [63:0] upd_img;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  unlock_gate i_unlock_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_ce_ni(ce_n), .bus_oe_ni(oe_n), .bus_we_ni(we_n), .bus_d0_i(d0),
    .abort_ni(abort_n), .abort_lock_i(lock), .cap_img_i(cap),
    .mem_ce_no(mem_ce_n), .rd_oe_o(rd_oe), .rd_d0_o(rd_d0),
    .upd_valid_o(upd_v), .upd_img_o(upd_img)
  );

  bit key_q[$];
  initial begin
    byte unsigned kb[4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 4; b++)
        for (int i = 0; i < 8; i++) key_q.push_back(kb[b][i]);
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int          m_ptr, m_cnt;
  bit          m_miss, m_xfer, m_allw, m_upd;
  bit          m_act, m_wr, m_rd, m_d;
  logic [63:0] m_img, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_cnt = 0; m_miss = 0; m_xfer = 0; m_allw = 0; m_upd = 0;
      m_act = 0; m_wr = 0; m_rd = 0; m_d = 0; m_img = '0; m_done = '0;
    end else begin
      m_upd = 0;
      if (!abort_n && !lock) begin
        m_xfer = 0; m_ptr = 0; m_miss = 0; m_cnt = 0;
      end else if (m_act && ce_n && (m_wr || m_rd)) begin
        if (!m_xfer) begin
          if (!m_wr) begin
            m_ptr = 0; m_miss = 0;
          end else if (!m_miss) begin
            if (m_d == key_q[m_ptr]) begin
              if (m_ptr == 63) begin
                m_xfer = 1; m_cnt = 0; m_img = cap; m_allw = 1; m_ptr = 0;
              end else m_ptr++;
            end else m_miss = 1;
          end
        end else begin
          if (m_wr) m_img[m_cnt] = m_d;
          else      m_allw = 0;
          m_cnt++;
          if (m_cnt == 64) begin
            m_xfer = 0; m_cnt = 0;
            if (m_allw) begin m_upd = 1; m_done = m_img; end
          end
        end
      end
      m_act = !ce_n;
      if (!ce_n) begin m_wr = !we_n; m_rd = !oe_n; m_d = d0; end
    end
  end

  // Compare on every clock, away from the driving edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(mem_ce_n == (ce_n | m_xfer), "R6/R7 mem_ce", 64'(mem_ce_n), 64'(ce_n | m_xfer));
      chk(rd_oe == (m_xfer && !ce_n && !oe_n && we_n), "R8 rd_oe", 64'(rd_oe),
          64'(m_xfer && !ce_n && !oe_n && we_n));
      if (rd_oe) chk(rd_d0 == m_img[m_cnt], "R8 rd_d0", 64'(rd_d0), 64'(m_img[m_cnt]));
      chk(upd_v == m_upd, "R10 upd_valid", 64'(upd_v), 64'(m_upd));
      if (upd_v && m_upd) chk(upd_img == m_done, "R9 upd_img", upd_img, m_done);
    end
  end

  task automatic wcyc(input bit b, input int n = 1);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; d0 = b;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rcyc(output bit got, output bit goe);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1;
    @(posedge clk); #1; got = rd_d0; goe = rd_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic rcyc_q();
    bit g, e;
    rcyc(g, e);
  endtask

  // Chip enable low with neither strobe: not a counted cycle (R12); returns mem_ce_no
  task automatic probe(output bit m);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1;
    @(posedge clk); #1; m = mem_ce_n;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic send_key(input int from = 0);
    for (int i = from; i < 64; i++) wcyc(key_q[i]);
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_n = 0;
    @(negedge clk); abort_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit m, g, e;
    logic [63:0] wimg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!upd_v && !rd_oe, "R1 outputs idle", {upd_v, rd_oe}, 0);
    probe(m);
    chk(m == 0, "R1 mem passes", 64'(m), 0);

    // Unlock and read the captured image out
    send_key();
    probe(m);
    chk(m == 1, "R5 R7 key unlocks", 64'(m), 1);
    for (int k = 0; k < 64; k++) begin
      rcyc(g, e);
      chk(e == 1 && g == cap[k], "R8 read bit", {e, g}, {1'b1, cap[k]});
    end
    probe(m);
    chk(m == 0, "R7 back to memory", 64'(m), 0);

    // Full write transfer commits
    wimg = 64'hDEAD_BEEF_0F1E_2D3C;
    send_key();
    for (int k = 0; k < 64; k++) wcyc(wimg[k]);
    @(posedge clk); #1;
    chk(upd_v == 1 && upd_img == wimg, "R9 R10 commit", upd_img, wimg);
    @(posedge clk); #1;
    chk(upd_v == 0, "R10 single pulse", 64'(upd_v), 0);

    // Mismatch freezes the pointer
    for (int i = 0; i < 10; i++) wcyc(key_q[i]);
    wcyc(!key_q[10]);
    send_key(11);
    send_key();
    probe(m);
    chk(m == 0, "R4 no unlock after miss", 64'(m), 0);
    rcyc_q();
    send_key();
    probe(m);
    chk(m == 1, "R2 read restarts", 64'(m), 1);
    for (int k = 0; k < 63; k++) rcyc_q();
    wcyc(1'b1);
    @(posedge clk); #1;
    chk(upd_v == 0, "R10 mixed no commit", 64'(upd_v), 0);

    // Read mid-key, long cycles and uncounted cycles
    for (int i = 0; i < 20; i++) wcyc(key_q[i]);
    rcyc_q();
    for (int i = 0; i < 30; i++) wcyc(key_q[i], (i % 3) + 1);
    probe(m);
    chk(m == 0, "R6 key cycles pass", 64'(m), 0);
    send_key(30);
    wimg = 64'hA5A5_0000_FFFF_3C3C;
    for (int k = 0; k < 64; k++) begin
      if (k % 16 == 5) begin
        probe(m);
        chk(m == 1, "R12 null cycle not counted", 64'(m), 1);
      end
      wcyc(wimg[k], (k % 2) + 1);
    end
    @(posedge clk); #1;
    chk(upd_v == 1 && upd_img == wimg, "R12 commit after held cycles", upd_img, wimg);

    // Abort unlocked ends transfer
    send_key();
    for (int k = 0; k < 10; k++) wcyc(1'b0);
    pulse_abort();
    probe(m);
    chk(m == 0, "R11 abort ends transfer", 64'(m), 0);
    for (int k = 0; k < 54; k++) wcyc(1'b0);
    @(posedge clk); #1;
    chk(upd_v == 0, "R11 no commit after abort", 64'(upd_v), 0);
    rcyc_q();

    // Abort masked by lock
    send_key();
    lock = 1;
    pulse_abort();
    probe(m);
    chk(m == 1, "R11 lock ignores abort", 64'(m), 1);
    wimg = 64'h1357_9BDF_2468_ACE0;
    for (int k = 0; k < 64; k++) wcyc(wimg[k]);
    @(posedge clk); #1;
    chk(upd_v == 1 && upd_img == wimg, "R11 locked transfer commits", upd_img, wimg);
    lock = 0;

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule